// File: doc/BRIEF.md
# Register-Programmed Serial Audio Crossbar

This block is a switch that sits between a chip's external serial audio ports and its internal audio controllers, such as I2S engines. Every connection carries one signal group: a bit clock, a frame sync and two data lines. Software programs the routing through a small word-addressed register bus. Each external port has a control word. That word names the port's source, which is either an internal controller or another external port. It also sets whether the port drives the clock pair and which way each data pin points. Each controller has a separate input-select word. That word names the external port that feeds its clock pair and the ports that feed each of its two receive data lines.

The routing path is purely combinational from the stored words. It produces the value for every port pin together with that pin's output enable, ready for a bidirectional pad. Several ports may take the same controller, so one controller's output can be broadcast to many ports. A controller listens to exactly the ports its own input-select word names.

No routing is checked for sense. Every possible setting, including conflicting ones, gives a fixed and repeatable result.

Top module: `audio_xbar`

## Requirements
- R1: On synchronous active-high reset every register holds zero. With all words zero, every port sources controller 1 with both data pins transmitting, and every controller takes clock, frame sync and both data lines from port 1.
- R2: Port control words sit at byte address 4*p for port p (p = 0..4). Controller input-select words sit at 0x40 + 4*k for controller k (k = 0..2). A port word stores bits 31, 30, 29 and 4:0. A controller word stores bits 31:28, 27:24 and 3:0. Every other bit reads back as zero.
- R3: A write to any other address, including one that is not word aligned, changes no register. A read of such an address returns zero.
- R4: A port whose select field (bits 4:0) holds 0, 1 or 2 sources controller 1, 2 or 3. It drives that controller's bit clock and frame sync with both output enables high, whatever the value of bit 31.
- R5: Bit 30 sets data pin 1 and bit 29 sets data pin 2 of a port. A value of 0 means transmit: the output enable is high and the pin carries the source's same-numbered data line. A value of 1 means receive: the output enable is low and the output value is zero.
- R6: A select field of 16 to 20 links the port to external port 1 to 5. Each transmitting data pin then carries the linked port's same-numbered data input.
- R7: On a port-to-port link, bit 31 set to 1 makes the port drive bit clock and frame sync, copied from the linked port's inputs, with the enables high. When bit 31 is 0, both enables are low and both values are zero.
- R8: Select values 3 to 15 and 21 to 31 leave a port undriven: all four output enables are low and all four outputs are zero, whatever bits 29 to 31 hold.
- R9: Bits 3:0 of a controller word pick the port (0 to 4 for ports 1 to 5) whose bit clock and frame sync inputs reach the controller. Values 5 to 15 give zero on both.
- R10: Bits 27:24 pick the port whose data-1 input reaches the controller's receive line 1. Bits 31:28 independently pick the port whose data-2 input reaches receive line 2. Values 5 to 15 give zero.
- R11: Any number of ports may select the same controller at once, and each of them carries that controller's signals.
- R12: A register write takes effect on the rising clock edge that accepts it. Routing outputs keep their old values until that edge and show the new routing from then on, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_bclk_i | input | 5 | Bit clock input from each external port pin |
| pin_fsync_i | input | 5 | Frame sync input from each external port pin |
| pin_d1_i | input | 5 | Data pin 1 input from each external port |
| pin_d2_i | input | 5 | Data pin 2 input from each external port |
| pin_bclk_o | output | 5 | Bit clock value driven toward each port |
| pin_bclk_oe | output | 5 | Bit clock output enable per port |
| pin_fsync_o | output | 5 | Frame sync value driven toward each port |
| pin_fsync_oe | output | 5 | Frame sync output enable per port |
| pin_d1_o | output | 5 | Data pin 1 value driven toward each port |
| pin_d1_oe | output | 5 | Data pin 1 output enable per port |
| pin_d2_o | output | 5 | Data pin 2 value driven toward each port |
| pin_d2_oe | output | 5 | Data pin 2 output enable per port |
| ctl_bclk_i | input | 3 | Bit clock produced by each controller |
| ctl_fsync_i | input | 3 | Frame sync produced by each controller |
| ctl_tx1_i | input | 3 | Transmit data line 1 of each controller |
| ctl_tx2_i | input | 3 | Transmit data line 2 of each controller |
| ctl_bclk_o | output | 3 | Bit clock delivered to each controller |
| ctl_fsync_o | output | 3 | Frame sync delivered to each controller |
| ctl_rx1_o | output | 3 | Receive data line 1 delivered to each controller |
| ctl_rx2_o | output | 3 | Receive data line 2 delivered to each controller |

## Verification
The hardest state to reach from the ports is a mixed routing. In it, some ports broadcast one controller while others form port-to-port links with differing master flags and pin directions, and the controllers listen to unrelated ports. Meanwhile other words hold unused codes, and every pin input must still be shown to land only where the words say. Random writes are biased toward legal select codes. They still leave a share of codes and out-of-range port numbers undefined. After every write the bench drives fresh random values on all pin and controller inputs, so that a wrongly chosen source shows up as a value mismatch. Directed steps add the unused-code bands, a broadcast of one controller to all five ports, and the edge on which a write first becomes visible.

// File: rtl/audio_xbar_pkg.sv
package audio_xbar_pkg;

    localparam int WORD_W         = 32;
    localparam int SEL_W          = 5;
    localparam int PICK_W         = 4;
    localparam int PORT_BASE      = 'h00;
    localparam int CTL_BASE       = 'h40;
    localparam int REG_STRIDE     = 4;
    localparam int PORT_CODE_BASE = 16;

    localparam logic [WORD_W-1:0] PORT_MASK = 32'hE000_001F;
    localparam logic [WORD_W-1:0] CTL_MASK  = 32'hFF00_000F;

    // one serial audio signal group
    typedef struct packed {
        logic bclk;
        logic fsync;
        logic d1;
        logic d2;
    } lane_t;

    typedef struct packed {
        logic             master;
        logic             d1_rx;
        logic             d2_rx;
        logic [SEL_W-1:0] sel;
    } port_cfg_t;

    typedef struct packed {
        logic [PICK_W-1:0] d2_pick;
        logic [PICK_W-1:0] d1_pick;
        logic [PICK_W-1:0] clk_pick;
    } ctl_cfg_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CTL  = 2'd1,
        SRC_PORT = 2'd2
    } src_kind_t;

    function automatic port_cfg_t port_cfg_of(input logic [WORD_W-1:0] w);
        port_cfg_t c;
        c.master = w[31];
        c.d1_rx  = w[30];
        c.d2_rx  = w[29];
        c.sel    = w[SEL_W-1:0];
        return c;
    endfunction

    function automatic ctl_cfg_t ctl_cfg_of(input logic [WORD_W-1:0] w);
        ctl_cfg_t c;
        c.d2_pick  = w[31:28];
        c.d1_pick  = w[27:24];
        c.clk_pick = w[PICK_W-1:0];
        return c;
    endfunction

    function automatic src_kind_t kind_of(input logic [SEL_W-1:0] sel,
                                          input int n_ctl, input int n_port);
        int s;
        s = int'(sel);
        if (s < n_ctl)
            return SRC_CTL;
        else if (s >= PORT_CODE_BASE && s < PORT_CODE_BASE + n_port)
            return SRC_PORT;
        else
            return SRC_NONE;
    endfunction

endpackage

// File: rtl/xbar_regs.sv
module xbar_regs
    import audio_xbar_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int NUM_CTLS  = 3,
    parameter int ADDR_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [WORD_W-1:0]                wdata,
    output logic [WORD_W-1:0]                rdata,
    output logic [NUM_PORTS-1:0][WORD_W-1:0] port_word,
    output logic [NUM_CTLS-1:0][WORD_W-1:0]  ctl_word
);

    logic [NUM_PORTS-1:0] port_hit;
    logic [NUM_CTLS-1:0]  ctl_hit;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_dec
        assign port_hit[p] = (addr == ADDR_W'(PORT_BASE + REG_STRIDE * p));
    end

    for (genvar k = 0; k < NUM_CTLS; k++) begin : g_ctl_dec
        assign ctl_hit[k] = (addr == ADDR_W'(CTL_BASE + REG_STRIDE * k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            port_word <= '0;
            ctl_word  <= '0;
        end else if (wr) begin
            for (int p = 0; p < NUM_PORTS; p++)
                if (port_hit[p]) port_word[p] <= wdata & PORT_MASK;
            for (int k = 0; k < NUM_CTLS; k++)
                if (ctl_hit[k]) ctl_word[k] <= wdata & CTL_MASK;
        end
    end

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (port_hit[p]) rdata = rdata | port_word[p];
        for (int k = 0; k < NUM_CTLS; k++)
            if (ctl_hit[k]) rdata = rdata | ctl_word[k];
    end

endmodule

// File: rtl/xbar_port_route.sv
module xbar_port_route
    import audio_xbar_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int NUM_CTLS  = 3
) (
    input  port_cfg_t                 cfg,
    input  lane_t [NUM_CTLS-1:0]      ctl_lanes,
    input  lane_t [NUM_PORTS-1:0]     pin_lanes,
    output lane_t                     out_val,
    output lane_t                     out_en
);

    localparam int CW = (NUM_CTLS  > 1) ? $clog2(NUM_CTLS)  : 1;
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    src_kind_t     kind;
    logic [CW-1:0] ctl_idx;
    logic [PW-1:0] peer_idx;
    lane_t         src;

    always_comb begin
        kind     = kind_of(cfg.sel, NUM_CTLS, NUM_PORTS);
        ctl_idx  = cfg.sel[CW-1:0];
        peer_idx = PW'(int'(cfg.sel) - PORT_CODE_BASE);
        src      = '0;
        out_en   = '0;
        case (kind)
            SRC_CTL: begin
                src          = ctl_lanes[ctl_idx];
                out_en.bclk  = 1'b1;
                out_en.fsync = 1'b1;
            end
            SRC_PORT: begin
                src          = pin_lanes[peer_idx];
                out_en.bclk  = cfg.master;
                out_en.fsync = cfg.master;
            end
            default: ;
        endcase
        if (kind != SRC_NONE) begin
            out_en.d1 = ~cfg.d1_rx;
            out_en.d2 = ~cfg.d2_rx;
        end
        out_val = src & out_en;
    end

endmodule

// File: rtl/xbar_ctl_route.sv
module xbar_ctl_route
    import audio_xbar_pkg::*;
#(
    parameter int NUM_PORTS = 5
) (
    input  ctl_cfg_t              cfg,
    input  lane_t [NUM_PORTS-1:0] pin_lanes,
    output lane_t                 rx
);

    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    function automatic logic pick_ok(input logic [PICK_W-1:0] v);
        return int'(v) < NUM_PORTS;
    endfunction

    always_comb begin
        rx = '0;
        if (pick_ok(cfg.clk_pick)) begin
            rx.bclk  = pin_lanes[cfg.clk_pick[PW-1:0]].bclk;
            rx.fsync = pin_lanes[cfg.clk_pick[PW-1:0]].fsync;
        end
        if (pick_ok(cfg.d1_pick))
            rx.d1 = pin_lanes[cfg.d1_pick[PW-1:0]].d1;
        if (pick_ok(cfg.d2_pick))
            rx.d2 = pin_lanes[cfg.d2_pick[PW-1:0]].d2;
    end

endmodule

// File: rtl/audio_xbar.sv
module audio_xbar
    import audio_xbar_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int NUM_CTLS  = 3,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_PORTS-1:0] pin_bclk_i,
    input  logic [NUM_PORTS-1:0] pin_fsync_i,
    input  logic [NUM_PORTS-1:0] pin_d1_i,
    input  logic [NUM_PORTS-1:0] pin_d2_i,
    output logic [NUM_PORTS-1:0] pin_bclk_o,
    output logic [NUM_PORTS-1:0] pin_bclk_oe,
    output logic [NUM_PORTS-1:0] pin_fsync_o,
    output logic [NUM_PORTS-1:0] pin_fsync_oe,
    output logic [NUM_PORTS-1:0] pin_d1_o,
    output logic [NUM_PORTS-1:0] pin_d1_oe,
    output logic [NUM_PORTS-1:0] pin_d2_o,
    output logic [NUM_PORTS-1:0] pin_d2_oe,
    input  logic [NUM_CTLS-1:0]  ctl_bclk_i,
    input  logic [NUM_CTLS-1:0]  ctl_fsync_i,
    input  logic [NUM_CTLS-1:0]  ctl_tx1_i,
    input  logic [NUM_CTLS-1:0]  ctl_tx2_i,
    output logic [NUM_CTLS-1:0]  ctl_bclk_o,
    output logic [NUM_CTLS-1:0]  ctl_fsync_o,
    output logic [NUM_CTLS-1:0]  ctl_rx1_o,
    output logic [NUM_CTLS-1:0]  ctl_rx2_o
);

    logic [NUM_PORTS-1:0][WORD_W-1:0] port_word;
    logic [NUM_CTLS-1:0][WORD_W-1:0]  ctl_word;

    lane_t [NUM_PORTS-1:0] pin_lanes;
    lane_t [NUM_CTLS-1:0]  ctl_lanes;

    xbar_regs #(
        .NUM_PORTS(NUM_PORTS),
        .NUM_CTLS (NUM_CTLS),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .port_word(port_word),
        .ctl_word (ctl_word)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        lane_t out_val;
        lane_t out_en;

        assign pin_lanes[p] = '{bclk: pin_bclk_i[p], fsync: pin_fsync_i[p],
                                d1: pin_d1_i[p], d2: pin_d2_i[p]};

        xbar_port_route #(
            .NUM_PORTS(NUM_PORTS),
            .NUM_CTLS (NUM_CTLS)
        ) u_route (
            .cfg      (port_cfg_of(port_word[p])),
            .ctl_lanes(ctl_lanes),
            .pin_lanes(pin_lanes),
            .out_val  (out_val),
            .out_en   (out_en)
        );

        assign pin_bclk_o[p]   = out_val.bclk;
        assign pin_fsync_o[p]  = out_val.fsync;
        assign pin_d1_o[p]     = out_val.d1;
        assign pin_d2_o[p]     = out_val.d2;
        assign pin_bclk_oe[p]  = out_en.bclk;
        assign pin_fsync_oe[p] = out_en.fsync;
        assign pin_d1_oe[p]    = out_en.d1;
        assign pin_d2_oe[p]    = out_en.d2;
    end

    for (genvar k = 0; k < NUM_CTLS; k++) begin : g_ctl
        lane_t rx;

        assign ctl_lanes[k] = '{bclk: ctl_bclk_i[k], fsync: ctl_fsync_i[k],
                                d1: ctl_tx1_i[k], d2: ctl_tx2_i[k]};

        xbar_ctl_route #(
            .NUM_PORTS(NUM_PORTS)
        ) u_route (
            .cfg      (ctl_cfg_of(ctl_word[k])),
            .pin_lanes(pin_lanes),
            .rx       (rx)
        );

        assign ctl_bclk_o[k]  = rx.bclk;
        assign ctl_fsync_o[k] = rx.fsync;
        assign ctl_rx1_o[k]   = rx.d1;
        assign ctl_rx2_o[k]   = rx.d2;
    end

endmodule

// File: rtl/audio_xbar_chk.sv
module audio_xbar_chk
    import audio_xbar_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int NUM_CTLS  = 3,
    parameter int ADDR_W    = 8
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             bus_wr,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic [31:0]                      bus_wdata,
    input logic [NUM_PORTS-1:0][WORD_W-1:0] port_word,
    input logic [NUM_CTLS-1:0][WORD_W-1:0]  ctl_word,
    input logic [NUM_PORTS-1:0]             pin_bclk_o,
    input logic [NUM_PORTS-1:0]             pin_bclk_oe,
    input logic [NUM_PORTS-1:0]             pin_fsync_o,
    input logic [NUM_PORTS-1:0]             pin_fsync_oe,
    input logic [NUM_PORTS-1:0]             pin_d1_o,
    input logic [NUM_PORTS-1:0]             pin_d1_oe,
    input logic [NUM_PORTS-1:0]             pin_d2_o,
    input logic [NUM_PORTS-1:0]             pin_d2_oe,
    input logic [NUM_CTLS-1:0]              ctl_bclk_o,
    input logic [NUM_CTLS-1:0]              ctl_fsync_o
);

    logic addr_mapped;
    always_comb begin
        addr_mapped = 1'b0;
        if (bus_addr[1:0] == 2'b00) begin
            if (int'(bus_addr) < REG_STRIDE * NUM_PORTS) addr_mapped = 1'b1;
            if (int'(bus_addr) >= CTL_BASE &&
                int'(bus_addr) < CTL_BASE + REG_STRIDE * NUM_CTLS) addr_mapped = 1'b1;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (port_word == '0 && ctl_word == '0));

    // R3
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !addr_mapped) |=> ($stable(port_word) && $stable(ctl_word)));

    // R5
    undriven_low_chk: assert property (@(posedge clk) disable iff (rst)
        ((pin_bclk_o & ~pin_bclk_oe) == '0) && ((pin_fsync_o & ~pin_fsync_oe) == '0) &&
        ((pin_d1_o & ~pin_d1_oe) == '0) && ((pin_d2_o & ~pin_d2_oe) == '0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
        // R2
        port_store_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == ADDR_W'(REG_STRIDE * p))
            |=> (port_word[p] == ($past(bus_wdata) & PORT_MASK)));

        // R4
        ctl_src_drive_chk: assert property (@(posedge clk) disable iff (rst)
            (int'(port_word[p][4:0]) < NUM_CTLS) |-> (pin_bclk_oe[p] && pin_fsync_oe[p]));

        // R8
        unused_code_chk: assert property (@(posedge clk) disable iff (rst)
            ((int'(port_word[p][4:0]) >= NUM_CTLS && int'(port_word[p][4:0]) < 16) ||
              int'(port_word[p][4:0]) >= 16 + NUM_PORTS)
            |-> !(pin_bclk_oe[p] || pin_fsync_oe[p] || pin_d1_oe[p] || pin_d2_oe[p]));
    end

    for (genvar k = 0; k < NUM_CTLS; k++) begin : g_ctl_chk
        // R9
        clk_pick_range_chk: assert property (@(posedge clk) disable iff (rst)
            (int'(ctl_word[k][3:0]) >= NUM_PORTS) |-> (!ctl_bclk_o[k] && !ctl_fsync_o[k]));
    end

endmodule

bind audio_xbar audio_xbar_chk #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_CTLS (NUM_CTLS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .port_word   (port_word),
    .ctl_word    (ctl_word),
    .pin_bclk_o  (pin_bclk_o),
    .pin_bclk_oe (pin_bclk_oe),
    .pin_fsync_o (pin_fsync_o),
    .pin_fsync_oe(pin_fsync_oe),
    .pin_d1_o    (pin_d1_o),
    .pin_d1_oe   (pin_d1_oe),
    .pin_d2_o    (pin_d2_o),
    .pin_d2_oe   (pin_d2_oe),
    .ctl_bclk_o  (ctl_bclk_o),
    .ctl_fsync_o (ctl_fsync_o)
);

// File: tb/audio_xbar_bench.sv
`timescale 1ns/1ps
module audio_xbar_bench;

    localparam int NP = 5;
    localparam int NC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_bclk_i = '0, pin_fsync_i = '0, pin_d1_i = '0, pin_d2_i = '0;
    logic [NP-1:0] pin_bclk_o, pin_bclk_oe, pin_fsync_o, pin_fsync_oe;
    logic [NP-1:0] pin_d1_o, pin_d1_oe, pin_d2_o, pin_d2_oe;
    logic [NC-1:0] ctl_bclk_i = '0, ctl_fsync_i = '0, ctl_tx1_i = '0, ctl_tx2_i = '0;
    logic [NC-1:0] ctl_bclk_o, ctl_fsync_o, ctl_rx1_o, ctl_rx2_o;

    logic [31:0] mp [NP];
    logic [31:0] mc [NC];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    audio_xbar u_audio_xbar (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_bclk_i(pin_bclk_i), .pin_fsync_i(pin_fsync_i),
        .pin_d1_i(pin_d1_i), .pin_d2_i(pin_d2_i),
        .pin_bclk_o(pin_bclk_o), .pin_bclk_oe(pin_bclk_oe),
        .pin_fsync_o(pin_fsync_o), .pin_fsync_oe(pin_fsync_oe),
        .pin_d1_o(pin_d1_o), .pin_d1_oe(pin_d1_oe),
        .pin_d2_o(pin_d2_o), .pin_d2_oe(pin_d2_oe),
        .ctl_bclk_i(ctl_bclk_i), .ctl_fsync_i(ctl_fsync_i),
        .ctl_tx1_i(ctl_tx1_i), .ctl_tx2_i(ctl_tx2_i),
        .ctl_bclk_o(ctl_bclk_o), .ctl_fsync_o(ctl_fsync_o),
        .ctl_rx1_o(ctl_rx1_o), .ctl_rx2_o(ctl_rx2_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [31:0] store_mask(input logic [7:0] a);
        if (a[1:0] == 2'b00 && a < 8'h14) return 32'hE000_001F;
        if (a[1:0] == 2'b00 && a >= 8'h40 && a < 8'h4C) return 32'hFF00_000F;
        return 32'h0;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        if (a[1:0] == 2'b00 && a < 8'h14) mp[a >> 2] = d & 32'hE000_001F;
        else if (a[1:0] == 2'b00 && a >= 8'h40 && a < 8'h4C) mc[(a - 8'h40) >> 2] = d & 32'hFF00_000F;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic shake_pins();
        pin_bclk_i  = NP'($urandom); pin_fsync_i = NP'($urandom);
        pin_d1_i    = NP'($urandom); pin_d2_i    = NP'($urandom);
        ctl_bclk_i  = NC'($urandom); ctl_fsync_i = NC'($urandom);
        ctl_tx1_i   = NC'($urandom); ctl_tx2_i   = NC'($urandom);
        #1;
    endtask

    // reference: routing computed from the model words and the current inputs
    task automatic check_routes(input string tag);
        logic [NP-1:0] eb, ebo, ef, efo, e1, e1o, e2, e2o;
        logic [NC-1:0] cb, cf, c1, c2;
        eb = '0; ebo = '0; ef = '0; efo = '0; e1 = '0; e1o = '0; e2 = '0; e2o = '0;
        cb = '0; cf = '0; c1 = '0; c2 = '0;
        for (int p = 0; p < NP; p++) begin
            int s;
            s = int'(mp[p][4:0]);
            if (s < NC) begin
                ebo[p] = 1'b1; eb[p] = ctl_bclk_i[s];
                efo[p] = 1'b1; ef[p] = ctl_fsync_i[s];
                if (!mp[p][30]) begin e1o[p] = 1'b1; e1[p] = ctl_tx1_i[s]; end
                if (!mp[p][29]) begin e2o[p] = 1'b1; e2[p] = ctl_tx2_i[s]; end
            end else if (s >= 16 && s < 16 + NP) begin
                if (mp[p][31]) begin
                    ebo[p] = 1'b1; eb[p] = pin_bclk_i[s-16];
                    efo[p] = 1'b1; ef[p] = pin_fsync_i[s-16];
                end
                if (!mp[p][30]) begin e1o[p] = 1'b1; e1[p] = pin_d1_i[s-16]; end
                if (!mp[p][29]) begin e2o[p] = 1'b1; e2[p] = pin_d2_i[s-16]; end
            end
        end
        for (int k = 0; k < NC; k++) begin
            int a, b, c;
            c = int'(mc[k][3:0]); a = int'(mc[k][27:24]); b = int'(mc[k][31:28]);
            if (c < NP) begin cb[k] = pin_bclk_i[c]; cf[k] = pin_fsync_i[c]; end
            if (a < NP) c1[k] = pin_d1_i[a];
            if (b < NP) c2[k] = pin_d2_i[b];
        end
        chk({tag, " bclk_o"},   32'(pin_bclk_o),   32'(eb));
        chk({tag, " bclk_oe"},  32'(pin_bclk_oe),  32'(ebo));
        chk({tag, " fsync_o"},  32'(pin_fsync_o),  32'(ef));
        chk({tag, " fsync_oe"}, 32'(pin_fsync_oe), 32'(efo));
        chk({tag, " d1_o"},     32'(pin_d1_o),     32'(e1));
        chk({tag, " d1_oe"},    32'(pin_d1_oe),    32'(e1o));
        chk({tag, " d2_o"},     32'(pin_d2_o),     32'(e2));
        chk({tag, " d2_oe"},    32'(pin_d2_oe),    32'(e2o));
        chk({tag, " ctl_bclk"}, 32'(ctl_bclk_o),   32'(cb));
        chk({tag, " ctl_fsync"},32'(ctl_fsync_o),  32'(cf));
        chk({tag, " ctl_rx1"},  32'(ctl_rx1_o),    32'(c1));
        chk({tag, " ctl_rx2"},  32'(ctl_rx2_o),    32'(c2));
    endtask

    task automatic shake_and_check(input string tag);
        shake_pins();
        check_routes(tag);
        shake_pins();
        check_routes(tag);
    endtask

    function automatic logic [31:0] rand_port_word();
        logic [31:0] w;
        int r;
        w = $urandom;
        r = $urandom % 10;
        if (r < 4)      w[4:0] = 5'($urandom % NC);
        else if (r < 8) w[4:0] = 5'(16 + $urandom % NP);
        return w;
    endfunction

    function automatic logic [31:0] rand_ctl_word();
        logic [31:0] w;
        w = $urandom;
        w[3:0]   = 4'($urandom % 7);
        w[27:24] = 4'($urandom % 7);
        w[31:28] = 4'($urandom % 7);
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int p = 0; p < NP; p++) mp[p] = '0;
        for (int k = 0; k < NC; k++) mc[k] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of registers and routing
        for (int p = 0; p < NP; p++) rd(8'(4 * p), 32'h0, "R1 port word after reset");
        for (int k = 0; k < NC; k++) rd(8'(8'h40 + 4 * k), 32'h0, "R1 ctl word after reset");
        shake_and_check("R1 routing after reset");

        // R2: storage masks and addresses
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'hE000_001F, "R2 port word mask");
        wr(8'h48, 32'hFFFF_FFFF);
        rd(8'h48, 32'hFF00_000F, "R2 ctl word mask");
        wr(8'h10, 32'h1234_5671);
        rd(8'h10, 32'h0000_0011, "R2 last port word");
        rd(8'h00, 32'h0, "R2 neighbour untouched");

        // R3: unmapped addresses
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h4C, 32'hFFFF_FFFF);
        wr(8'h41, 32'hFFFF_FFFF);
        rd(8'h14, 32'h0, "R3 read unmapped 0x14");
        rd(8'h02, 32'h0, "R3 read unaligned 0x02");
        rd(8'h4C, 32'h0, "R3 read unmapped 0x4C");
        for (int p = 0; p < NP; p++) rd(8'(4 * p), mp[p], "R3 port words unchanged");
        for (int k = 0; k < NC; k++) rd(8'(8'h40 + 4 * k), mc[k], "R3 ctl words unchanged");

        // R11 and R4: every port takes controller 2
        for (int p = 0; p < NP; p++) wr(8'(4 * p), 32'h0000_0001);
        shake_and_check("R11 R4 broadcast");

        // R4 and R5: controller links with mixed directions, master flag ignored
        wr(8'h00, 32'h4000_0000);
        wr(8'h04, 32'h2000_0002);
        wr(8'h08, 32'h8000_0001);
        wr(8'h0C, 32'h6000_0000);
        shake_and_check("R4 R5 controller links");

        // R6 and R7: port to port links
        wr(8'h0C, 32'h8000_0010);
        wr(8'h10, 32'h4000_0014);
        wr(8'h00, 32'h2000_0012);
        wr(8'h04, 32'hA000_0013);
        shake_and_check("R6 R7 port links");

        // R8: unused codes
        wr(8'h00, 32'h0000_0003);
        wr(8'h04, 32'hE000_000F);
        wr(8'h08, 32'h8000_0015);
        wr(8'h0C, 32'h0000_001F);
        shake_and_check("R8 unused codes");

        // R9 and R10: controller input picks, in and out of range
        wr(8'h40, 32'h3000_0004);
        wr(8'h44, 32'h4900_0005);
        wr(8'h48, 32'hF400_000F);
        shake_and_check("R9 R10 controller picks");

        // R12: write visible exactly at the accepting edge
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h8000_0011;
        shake_pins();
        check_routes("R12 before edge");
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(8'h00, 32'h8000_0011);
        #1 check_routes("R12 after edge");

        // random mix: R4 R5 R6 R7 R9 R10
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom % 8;
            if (r < NP) wr(8'(4 * r), rand_port_word());
            else        wr(8'(8'h40 + 4 * (r - NP)), rand_ctl_word());
            shake_pins();
            check_routes("random R4 R5 R6 R7 R9 R10");
            if (i % 16 == 0) begin
                int a;
                a = $urandom % 8;
                if (a < NP) rd(8'(4 * a), mp[a], "random R2 readback");
                else        rd(8'(8'h40 + 4 * (a - NP)), mc[a - NP], "random R2 readback");
            end
        end

        if (store_mask(8'h14) != 32'h0) chk("R3 bench mask", store_mask(8'h14), 32'h0);
        done = 1;
        summary();
    end

endmodule